// File: doc/BRIEF.md
# Two-Channel Linked-Descriptor Display Fetcher

This block reads display data for a panel controller out of system memory. It has two channels. Channel 0 drives a single panel, or the top half of a split panel. Channel 1 drives the bottom half of a split panel and is held back unless split mode is selected. Software programs one thing per channel: the address of the next descriptor. Every other channel setting comes from a four-word descriptor that the block reads from memory itself.

Word 0 of each descriptor gives the next link in the chain. Buffers can therefore be scattered through memory. A descriptor flagged as palette sends its words to a separate palette stream instead of the pixel stream.

Both channels share one read port. A fixed-priority arbiter controls that port and gives it out one whole burst at a time. Read data comes back one word per beat. Each beat is forwarded to the pixel stream or the palette stream in the same cycle it arrives.

Top module: `dfetch_top`

## Requirements
- R1: While reset is held and after it is released, `mem_req`, `pix_valid`, `pal_valid`, `eof_pulse` and `bus_err` are all 0, and both frame ID outputs are 0.
- R2: A descriptor is read as one 4-word burst at the channel's next-descriptor address. The beats arrive in this order: next-descriptor address, buffer address, frame ID, command. After the fetch, the frame ID appears on that channel's `frame_idN` output.
- R3: In the command word, bits [15:0] hold the buffer length in bytes, and the buffer holds length/4 words. Those words are read from ascending addresses that start at the buffer address. Bursts are `MAX_BURST` words long, except the final one, which carries whatever remains. Each beat appears once on `pix_data` or `pal_data`.
- R4: After the final data beat of a buffer, the channel's next request is a descriptor fetch from the address that word 0 supplied. No further data reads come first.
- R5: A next-descriptor address with bits [3:0] not zero sets the channel's `bus_err` bit and stops the channel, with no request issued. This applies both to an address written by software and to one taken from word 0. The bit stays set until software writes that channel's address again; that write clears the bit and restarts the channel.
- R6: Command bit 17 set on channel 0 sends the buffer's beats to `pal_valid`/`pal_data`. On channel 1 this bit is ignored, and the beats go to the pixel stream.
- R7: Command bit 16 set produces a one-cycle pulse on the channel's `eof_pulse` bit, in the same cycle as the buffer's final data beat. If the length is zero, the pulse comes with the last descriptor beat and no data is read.
- R8: Channel 1 issues requests only while `dual_mode` is 1. Channel 0 does not depend on `dual_mode`.
- R9: When both channels have a request pending, channel 0 is granted first. A grant holds the port until every beat of that burst has arrived. `pix_lower` is 1 exactly on pixel beats that belong to channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | Split-panel mode; lets channel 1 run |
| sw_wr_en | input | 1 | Software write strobe for a next-descriptor register |
| sw_wr_ch | input | 1 | Channel selected by the write |
| sw_wr_addr | input | 32 | Next-descriptor address written |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | First byte address of the burst |
| mem_len | output | 3 | Beats in the burst |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| pix_valid | output | 1 | Pixel word valid |
| pix_data | output | 32 | Pixel word |
| pix_lower | output | 1 | Pixel word belongs to the lower half (channel 1) |
| pal_valid | output | 1 | Palette word valid |
| pal_data | output | 32 | Palette word |
| eof_pulse | output | 2 | Per-channel end-of-buffer pulse |
| bus_err | output | 2 | Per-channel misaligned-descriptor status |
| frame_id0 | output | 32 | Frame ID of channel 0's current descriptor |
| frame_id1 | output | 32 | Frame ID of channel 1's current descriptor |

## Verification
The bench builds the block with the default `MAX_BURST` of 4. That value is small enough that a six-word buffer has to split into a full burst and a two-word tail, and a one-word buffer sends the shortest possible burst. A descriptor fetch is itself 4 beats, so it is exactly the size of a full data burst, and the beat counter's boundary is tested from both sides. The bench loads chains of up to three descriptors. They include a palette buffer, a zero-length buffer, and links that end on a misaligned address. It also turns `dual_mode` on at the point where both channels become ready together, which makes the priority rule visible.

// File: rtl/dfetch_pkg.sv
package dfetch_pkg;
    localparam int unsigned NCH         = 2;
    localparam int unsigned DESC_WORDS  = 4;
    localparam int unsigned CMD_LEN_W   = 16;
    localparam int unsigned CMD_IRQ_BIT = 16;
    localparam int unsigned CMD_PAL_BIT = 17;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_DESC_WAIT,
        CH_DESC_RX,
        CH_DATA_WAIT,
        CH_DATA_RX,
        CH_HALT
    } ch_state_e;
endpackage

// File: rtl/dfetch_chan.sv
module dfetch_chan
    import dfetch_pkg::*;
#(
    parameter int unsigned CH_IDX    = 0,
    parameter int unsigned MAX_BURST = 4,
    parameter int unsigned LEN_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             arm,
    input  logic [31:0]      arm_addr,
    output logic             req,
    output logic [31:0]      req_addr,
    output logic [LEN_W-1:0] req_len,
    input  logic             grant,
    input  logic             beat,
    input  logic             beat_last,
    input  logic [31:0]      beat_data,
    output logic             out_valid,
    output logic             out_pal,
    output logic             eof,
    output logic             err,
    output logic [31:0]      frame_id
);
    localparam int unsigned WL_W = CMD_LEN_W - 2;
    localparam logic [WL_W-1:0] MAXB = WL_W'(MAX_BURST);
    localparam logic PAL_OK = (CH_IDX == 0);

    typedef struct packed {
        ch_state_e       st;
        logic [31:0]     nda;
        logic [31:0]     src;
        logic [31:0]     id;
        logic [WL_W-1:0] left;
        logic            irq;
        logic            pal;
        logic [1:0]      didx;
        logic            err;
    } chan_s;

    chan_s s_d, s_q;
    logic [WL_W-1:0] len_words;

    assign len_words = beat_data[CMD_LEN_W-1:2];

    always_comb begin
        s_d       = s_q;
        req       = 1'b0;
        req_addr  = '0;
        req_len   = '0;
        eof       = 1'b0;
        out_valid = 1'b0;
        unique case (s_q.st)
            CH_DESC_WAIT: begin
                if (s_q.nda[3:0] != 4'd0) begin
                    s_d.err = 1'b1;
                    s_d.st  = CH_HALT;
                end else if (enable) begin
                    req      = 1'b1;
                    req_addr = s_q.nda;
                    req_len  = LEN_W'(DESC_WORDS);
                    if (grant) begin
                        s_d.st   = CH_DESC_RX;
                        s_d.didx = 2'd0;
                    end
                end
            end
            CH_DESC_RX: begin
                if (beat) begin
                    s_d.didx = s_q.didx + 2'd1;
                    unique case (s_q.didx)
                        2'd0: s_d.nda = beat_data;
                        2'd1: s_d.src = beat_data;
                        2'd2: s_d.id  = beat_data;
                        default: begin
                            s_d.left = len_words;
                            s_d.irq  = beat_data[CMD_IRQ_BIT];
                            s_d.pal  = beat_data[CMD_PAL_BIT];
                            if (len_words == '0) begin
                                eof    = beat_data[CMD_IRQ_BIT];
                                s_d.st = CH_DESC_WAIT;
                            end else begin
                                s_d.st = CH_DATA_WAIT;
                            end
                        end
                    endcase
                end
            end
            CH_DATA_WAIT: begin
                if (enable) begin
                    req      = 1'b1;
                    req_addr = s_q.src;
                    req_len  = (s_q.left > MAXB) ? LEN_W'(MAX_BURST)
                                                 : LEN_W'(s_q.left);
                    if (grant) s_d.st = CH_DATA_RX;
                end
            end
            CH_DATA_RX: begin
                if (beat) begin
                    out_valid = 1'b1;
                    s_d.src   = s_q.src + 32'd4;
                    s_d.left  = s_q.left - WL_W'(1);
                    if (beat_last) begin
                        if (s_q.left == WL_W'(1)) begin
                            eof    = s_q.irq;
                            s_d.st = CH_DESC_WAIT;
                        end else begin
                            s_d.st = CH_DATA_WAIT;
                        end
                    end
                end
            end
            default: ;
        endcase
        if (arm) begin
            s_d.nda = arm_addr;
            s_d.err = 1'b0;
            s_d.st  = CH_DESC_WAIT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= CH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_pal  = s_q.pal & PAL_OK;
    assign err      = s_q.err;
    assign frame_id = s_q.id;
endmodule

// File: rtl/dfetch_arb.sv
module dfetch_arb
    import dfetch_pkg::*;
#(
    parameter int unsigned LEN_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             req,
    input  logic [NCH-1:0][31:0]       req_addr,
    input  logic [NCH-1:0][LEN_W-1:0]  req_len,
    output logic                       mem_req,
    output logic [31:0]                mem_addr,
    output logic [LEN_W-1:0]           mem_len,
    input  logic                       mem_gnt,
    input  logic                       mem_rvalid,
    output logic [NCH-1:0]             grant,
    output logic [NCH-1:0]             beat,
    output logic                       beat_last
);
    localparam int unsigned OW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic             busy;
        logic [OW-1:0]    owner;
        logic [LEN_W-1:0] left;
    } arb_s;

    arb_s a_d, a_q;
    logic [OW-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) sel = OW'(i);
        end
    end

    always_comb begin
        a_d       = a_q;
        grant     = '0;
        beat      = '0;
        beat_last = 1'b0;
        mem_req   = !a_q.busy && (|req);
        mem_addr  = req_addr[sel];
        mem_len   = req_len[sel];
        if (mem_req && mem_gnt) begin
            grant[sel] = 1'b1;
            a_d.busy   = 1'b1;
            a_d.owner  = sel;
            a_d.left   = req_len[sel];
        end
        if (a_q.busy && mem_rvalid) begin
            beat[a_q.owner] = 1'b1;
            a_d.left        = a_q.left - LEN_W'(1);
            if (a_q.left == LEN_W'(1)) begin
                beat_last = 1'b1;
                a_d.busy  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end
endmodule

// File: rtl/dfetch_top.sv
module dfetch_top
    import dfetch_pkg::*;
#(
    parameter int unsigned MAX_BURST = 4,
    localparam int unsigned BMAX     = (MAX_BURST > DESC_WORDS) ? MAX_BURST : DESC_WORDS,
    localparam int unsigned LEN_W    = $clog2(BMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dual_mode,
    input  logic             sw_wr_en,
    input  logic             sw_wr_ch,
    input  logic [31:0]      sw_wr_addr,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    output logic [LEN_W-1:0] mem_len,
    input  logic             mem_gnt,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             pix_valid,
    output logic [31:0]      pix_data,
    output logic             pix_lower,
    output logic             pal_valid,
    output logic [31:0]      pal_data,
    output logic [1:0]       eof_pulse,
    output logic [1:0]       bus_err,
    output logic [31:0]      frame_id0,
    output logic [31:0]      frame_id1
);
    logic [NCH-1:0]            ch_req, ch_grant, ch_beat, ch_valid, ch_pal;
    logic [NCH-1:0]            ch_arm, ch_en, ch_eof, ch_err;
    logic [NCH-1:0][31:0]      ch_addr, ch_id;
    logic [NCH-1:0][LEN_W-1:0] ch_len;
    logic                      beat_last;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_arm[g] = sw_wr_en && (sw_wr_ch == 1'(g));
        if (g == 0) begin : g_main
            assign ch_en[g] = 1'b1;
        end else begin : g_lower
            assign ch_en[g] = dual_mode;
        end
        dfetch_chan #(
            .CH_IDX   (g),
            .MAX_BURST(MAX_BURST),
            .LEN_W    (LEN_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (ch_en[g]),
            .arm      (ch_arm[g]),
            .arm_addr (sw_wr_addr),
            .req      (ch_req[g]),
            .req_addr (ch_addr[g]),
            .req_len  (ch_len[g]),
            .grant    (ch_grant[g]),
            .beat     (ch_beat[g]),
            .beat_last(beat_last),
            .beat_data(mem_rdata),
            .out_valid(ch_valid[g]),
            .out_pal  (ch_pal[g]),
            .eof      (ch_eof[g]),
            .err      (ch_err[g]),
            .frame_id (ch_id[g])
        );
    end

    dfetch_arb #(.LEN_W(LEN_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ch_req),
        .req_addr  (ch_addr),
        .req_len   (ch_len),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_len   (mem_len),
        .mem_gnt   (mem_gnt),
        .mem_rvalid(mem_rvalid),
        .grant     (ch_grant),
        .beat      (ch_beat),
        .beat_last (beat_last)
    );

    assign pix_valid = |(ch_valid & ~ch_pal);
    assign pal_valid = |(ch_valid & ch_pal);
    assign pix_lower = ch_valid[1];
    assign pix_data  = mem_rdata;
    assign pal_data  = mem_rdata;
    assign eof_pulse = ch_eof;
    assign bus_err   = ch_err;
    assign frame_id0 = ch_id[0];
    assign frame_id1 = ch_id[1];
endmodule

// File: rtl/dfetch_chk.sv
module dfetch_chk #(
    parameter int unsigned LEN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dual_mode,
    input logic             sw_wr_en,
    input logic             sw_wr_ch,
    input logic             mem_req,
    input logic [LEN_W-1:0] mem_len,
    input logic             mem_rvalid,
    input logic             pix_valid,
    input logic             pal_valid,
    input logic [1:0]       bus_err,
    input logic [1:0]       ch_req,
    input logic [1:0]       ch_grant
);
    p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_grant));

    p_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ch_grant[1] |-> !ch_req[0]);

    p_lower_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ch_req[1] |-> dual_mode);

    p_halt_quiet0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err[0] |-> !ch_req[0]);

    p_halt_quiet1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err[1] |-> !ch_req[1]);

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err[0] && !(sw_wr_en && !sw_wr_ch)) |=> bus_err[0]);

    p_stream_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid && pal_valid));

    p_beat_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid || pal_valid) |-> mem_rvalid);

    p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0));
endmodule

bind dfetch_top dfetch_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dual_mode (dual_mode),
    .sw_wr_en  (sw_wr_en),
    .sw_wr_ch  (sw_wr_ch),
    .mem_req   (mem_req),
    .mem_len   (mem_len),
    .mem_rvalid(mem_rvalid),
    .pix_valid (pix_valid),
    .pal_valid (pal_valid),
    .bus_err   (bus_err),
    .ch_req    (ch_req),
    .ch_grant  (ch_grant)
);

// File: tb/dfetch_top_test.sv
`timescale 1ns/1ps
module dfetch_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dual_mode = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic        sw_wr_ch = 1'b0;
    logic [31:0] sw_wr_addr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [2:0]  mem_len;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        pix_valid, pix_lower, pal_valid;
    logic [31:0] pix_data, pal_data, frame_id0, frame_id1;
    logic [1:0]  eof_pulse, bus_err;

    always #2.5 clk = ~clk;

    dfetch_top uut (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
        .sw_wr_en(sw_wr_en), .sw_wr_ch(sw_wr_ch), .sw_wr_addr(sw_wr_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_lower(pix_lower),
        .pal_valid(pal_valid), .pal_data(pal_data), .eof_pulse(eof_pulse),
        .bus_err(bus_err), .frame_id0(frame_id0), .frame_id1(frame_id1)
    );

    // kind: 0 upper pixel, 1 lower pixel, 2 palette, 3 eof ch0, 4 eof ch1, 5 request
    typedef struct packed {
        logic [2:0]  kind;
        logic [3:0]  len;
        logic [31:0] data;
    } vec_t;

    localparam int NVEC = 31;
    localparam vec_t VEC [NVEC] = '{
        '{3'd5, 4'd4, 32'h040}, '{3'd5, 4'd3, 32'h200}, '{3'd5, 4'd4, 32'h080},
        '{3'd5, 4'd2, 32'h300}, '{3'd5, 4'd4, 32'h0C0}, '{3'd5, 4'd4, 32'h240},
        '{3'd5, 4'd2, 32'h250},
        '{3'd0, 4'd0, 32'hD000_0200}, '{3'd0, 4'd0, 32'hD000_0204},
        '{3'd0, 4'd0, 32'hD000_0208}, '{3'd3, 4'd0, 32'h0},
        '{3'd2, 4'd0, 32'hD000_0300}, '{3'd2, 4'd0, 32'hD000_0304},
        '{3'd0, 4'd0, 32'hD000_0240}, '{3'd0, 4'd0, 32'hD000_0244},
        '{3'd0, 4'd0, 32'hD000_0248}, '{3'd0, 4'd0, 32'hD000_024C},
        '{3'd0, 4'd0, 32'hD000_0250}, '{3'd0, 4'd0, 32'hD000_0254},
        '{3'd3, 4'd0, 32'h0},
        '{3'd5, 4'd4, 32'h180}, '{3'd5, 4'd1, 32'h3C0}, '{3'd5, 4'd4, 32'h140},
        '{3'd5, 4'd2, 32'h380},
        '{3'd0, 4'd0, 32'hD000_03C0}, '{3'd3, 4'd0, 32'h0},
        '{3'd1, 4'd0, 32'hD000_0380}, '{3'd1, 4'd0, 32'hD000_0384},
        '{3'd4, 4'd0, 32'h0},
        '{3'd5, 4'd4, 32'h1C0}, '{3'd3, 4'd0, 32'h0}
    };

    logic [31:0] mem [256];
    logic [31:0] rq_addr [64];
    logic [3:0]  rq_len  [64];
    logic [2:0]  ev_kind [64];
    logic [31:0] ev_data [64];
    int nreq = 0, nev = 0, nchk = 0, nfail = 0;
    logic done = 1'b0;
    logic        m_busy = 1'b0;
    logic [31:0] m_ptr = '0;
    int          m_left = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input int a, input logic [31:0] nxt, src, id, cmd);
        mem[a/4]     = nxt;
        mem[a/4 + 1] = src;
        mem[a/4 + 2] = id;
        mem[a/4 + 3] = cmd;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic sw_write(input logic ch, input logic [31:0] a);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_ch = ch; sw_wr_addr = a;
        @(negedge clk);
        sw_wr_en = 1'b0;
        #1;
    endtask

    // memory model and output monitor
    always @(negedge clk) begin
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b0;
        if (!rst_n) begin
            m_busy = 1'b0;
        end else if (m_busy) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[m_ptr[9:2]];
            m_ptr      = m_ptr + 32'd4;
            m_left--;
            if (m_left == 0) m_busy = 1'b0;
        end else if (mem_req) begin
            mem_gnt = 1'b1;
            m_ptr   = mem_addr;
            m_left  = int'(mem_len);
            m_busy  = 1'b1;
            rq_addr[nreq] = mem_addr;
            rq_len[nreq]  = 4'(mem_len);
            nreq++;
        end
        #1;
        if (pix_valid) begin
            ev_kind[nev] = pix_lower ? 3'd1 : 3'd0; ev_data[nev] = pix_data; nev++;
        end
        if (pal_valid) begin
            ev_kind[nev] = 3'd2; ev_data[nev] = pal_data; nev++;
        end
        if (eof_pulse[0]) begin
            ev_kind[nev] = 3'd3; ev_data[nev] = '0; nev++;
        end
        if (eof_pulse[1]) begin
            ev_kind[nev] = 3'd4; ev_data[nev] = '0; nev++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 | (i << 2);
        put_desc(32'h040, 32'h080, 32'h200, 32'h11, 32'h0001_000C);
        put_desc(32'h080, 32'h0C0, 32'h300, 32'h22, 32'h0002_0008);
        put_desc(32'h0C0, 32'h104, 32'h240, 32'h33, 32'h0001_0018);
        put_desc(32'h140, 32'h1C4, 32'h380, 32'h55, 32'h0003_0008);
        put_desc(32'h180, 32'h1A8, 32'h3C0, 32'h66, 32'h0001_0004);
        put_desc(32'h1C0, 32'h1E4, 32'h000, 32'h77, 32'h0001_0000);

        wait_cyc(3);
        chk("R1 mem_req in reset", 32'(mem_req), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 streams", {29'd0, pix_valid, pal_valid, 1'b0}, 0);
        chk("R1 bus_err", 32'(bus_err), 0);
        chk("R1 frame_id0", frame_id0, 0);

        // misaligned software-written address
        sw_write(1'b0, 32'h44);
        wait_cyc(3);
        chk("R5 err on bad write", 32'(bus_err), 32'h1);
        chk("R5 no request", nreq, 0);

        // scenario 1: three-link chain on channel 0
        sw_write(1'b0, 32'h40);
        chk("R5 rewrite clears err", 32'(bus_err[0]), 0);
        wait_cyc(150);
        chk("R5 chain ends in err", 32'(bus_err), 32'h1);
        chk("R2 frame_id0 last", frame_id0, 32'h33);

        // scenario 2: split panel, simultaneous start
        sw_write(1'b1, 32'h140);
        wait_cyc(10);
        chk("R8 lower idle without dual_mode", nreq, 7);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_ch = 1'b0; sw_wr_addr = 32'h180; dual_mode = 1'b1;
        @(negedge clk);
        sw_wr_en = 1'b0;
        wait_cyc(80);
        chk("R9 ch0 data before ch1 desc", rq_addr[8], 32'h3C0);
        chk("R5 both halted", 32'(bus_err), 32'h3);
        chk("R2 frame_id0", frame_id0, 32'h66);
        chk("R2 frame_id1", frame_id1, 32'h55);

        // scenario 3: zero-length buffer with end pulse
        sw_write(1'b0, 32'h1C0);
        wait_cyc(40);
        chk("R7 zero-length id", frame_id0, 32'h77);
        chk("R5 err after zero-length", 32'(bus_err), 32'h3);

        chk("R4 request count", nreq, 12);
        chk("R3 event count", nev, 19);
        begin
            int rq = 0, ev = 0;
            for (int i = 0; i < NVEC; i++) begin
                if (VEC[i].kind == 3'd5) begin
                    chk("R2/R4 request addr", rq_addr[rq], VEC[i].data);
                    chk("R3 request len", 32'(rq_len[rq]), 32'(VEC[i].len));
                    rq++;
                end else begin
                    case (VEC[i].kind)
                        3'd2:      chk("R6 stream kind", 32'(ev_kind[ev]), 32'(VEC[i].kind));
                        3'd1:      chk("R9 stream kind", 32'(ev_kind[ev]), 32'(VEC[i].kind));
                        3'd3, 3'd4: chk("R7 stream kind", 32'(ev_kind[ev]), 32'(VEC[i].kind));
                        default:   chk("R3 stream kind", 32'(ev_kind[ev]), 32'(VEC[i].kind));
                    endcase
                    chk("R3 stream data", ev_data[ev], VEC[i].data);
                    ev++;
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule